// File: doc/BRIEF.md
# Cell Program Sequencer with Hardware Loops

This block is the control unit of one compute cell in a mesh of cells. It reads 24-bit instruction words from a program memory that the cell shares with a host, decodes them, and turns them into one-cycle strobes that set up the datapath (configuration, control, register clear and address-generator load). It also handles branching, a counted loop pair, repeat/delay counts inside an instruction, and a halt state that the host releases with a start pulse.

Every instruction costs one fetch cycle, with the memory read enabled, and one execute cycle. Control and reset instructions may add cycles on top of that. A halt instruction raises the status output and records a resume address. The next host start pulse sends the sequencer to that address. After the global reset the cell sits halted with a resume address of 0, so the host can load a program and then start it.

Top module: `cellseq_top`

## Requirements
- R1: While reset is held and after it is released, `status` is 1, `pm_rd_en` and all four strobes are 0. The first host start fetches from address 0.
- R2: Each instruction takes one cycle with `pm_rd_en`=1 and `pm_addr` equal to the program counter, then one execute cycle. Without a branch the next fetch address is the previous one plus 1, modulo 128. The memory returns the word one cycle after the read.
- R3: Opcode 1 (configure) pulses `cfg_valid` for one cycle with `cfg_data` = word[15:0]. Opcode 9 (load) pulses `ld_valid` for one cycle with `ld_data` = word[15:0].
- R4: Opcode 2 (control) has its control field in word[19:8] and a count N in word[7:0]. It raises `ctl_valid` with that field for N consecutive cycles when N≥2, and for one cycle when N is 0 or 1, before the next fetch.
- R5: Opcode 3 (jump) fetches next from word[6:0].
- R6: Opcode 4 (conditional jump) fetches next from word[6:0] when `cond_in` is 0 in its execute cycle. Otherwise it falls through.
- R7: Opcode 5 (loop start) loads a loop count from word[6:0]. Opcode 6 (loop end) branches to word[6:0] and decrements while the count is above 1, else clears it and falls through. A count of 0 or 1 runs the body once. Control repeats nest inside this loop.
- R8: Opcode 7 (halt) raises `status` and keeps the cell idle until a host start. It then fetches from word[6:0] of the halt and drops `status`.
- R9: A host start pulse while `status` is 0 has no effect on the instruction flow or on `status`.
- R10: Opcode 8 (reset) pulses `rst_valid` for one cycle with `rst_mask` = word[15:8]. It then stalls N = word[7:0] further cycles before the next fetch.
- R11: Opcodes 0 and 10 to 15 produce no strobe and fall through to the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_rd_en | output | 1 | Program memory read enable (fetch cycle) |
| pm_addr | output | 7 | Program memory read address |
| pm_rdata | input | 24 | Instruction word, valid one cycle after the read |
| cond_in | input | 1 | Condition value tested by the conditional jump |
| host_start | input | 1 | Host start pulse, acted on only while halted |
| status | output | 1 | 1 while halted, 0 while running |
| cfg_valid | output | 1 | Configuration strobe |
| cfg_data | output | 16 | Configuration field |
| ctl_valid | output | 1 | Control strobe, repeated for counted control |
| ctl_data | output | 12 | Control field |
| rst_valid | output | 1 | Datapath register-clear strobe |
| rst_mask | output | 8 | Select mask of registers to clear |
| ld_valid | output | 1 | Address generator load strobe |
| ld_data | output | 16 | Base and limit field for the load |

## Verification
The hardest situation to reach from the ports is a host start pulse that lands while the cell is busy. The worst case is when it coincides with the execute cycle of a halt instruction, so that it must neither restart the cell nor be remembered. The stimulus runs randomly built programs and raises `host_start` at a chosen cycle of the run. It then compares the full strobe trace, fetch address trace and run length with what the bench's instruction-level model predicts. Those programs combine a counted loop, repeated control and stalled reset inside the loop body, and both conditional-jump outcomes, so the two loop levels are exercised together.

// File: rtl/cellseq_pkg.sv
// Package: shared widths, opcode and state encodings for the cell sequencer.
// Assumes a 24-bit instruction with the opcode in the top four bits.
package cellseq_pkg;
    localparam int PC_W    = 7;
    localparam int INSTR_W = 24;
    localparam int CNT_W   = 8;
    localparam int CFG_W   = 16;
    localparam int CTL_W   = 12;
    localparam int MASK_W  = 8;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_CFG   = 4'd1,
        OP_CTL   = 4'd2,
        OP_JMP   = 4'd3,
        OP_JZ    = 4'd4,
        OP_LOOPS = 4'd5,
        OP_LOOPE = 4'd6,
        OP_HALT  = 4'd7,
        OP_RST   = 4'd8,
        OP_LD    = 4'd9
    } opcode_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

    typedef struct packed {
        opcode_e              op;
        logic [PC_W-1:0]      target;
        logic [PC_W-1:0]      loop_n;
        logic [CNT_W-1:0]     wait_n;
        logic [CFG_W-1:0]     word16;
        logic [CTL_W-1:0]     ctl;
        logic [MASK_W-1:0]    mask;
    } instr_t;
endpackage

// File: rtl/cellseq_decode.sv
// Module: splits a raw instruction word into its fields.
// Assumes undefined opcodes behave as no-operation.
module cellseq_decode
    import cellseq_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output instr_t             fields
);
    // Purpose: map opcode bits and slice fixed field positions.
    always_comb begin
        case (word[INSTR_W-1 -: 4])
            4'd1:    fields.op = OP_CFG;
            4'd2:    fields.op = OP_CTL;
            4'd3:    fields.op = OP_JMP;
            4'd4:    fields.op = OP_JZ;
            4'd5:    fields.op = OP_LOOPS;
            4'd6:    fields.op = OP_LOOPE;
            4'd7:    fields.op = OP_HALT;
            4'd8:    fields.op = OP_RST;
            4'd9:    fields.op = OP_LD;
            default: fields.op = OP_NOP;
        endcase
        fields.target = word[PC_W-1:0];
        fields.loop_n = word[PC_W-1:0];
        fields.wait_n = word[CNT_W-1:0];
        fields.word16 = word[CFG_W-1:0];
        fields.ctl    = word[CNT_W +: CTL_W];
        fields.mask   = word[CNT_W +: MASK_W];
    end
endmodule

// File: rtl/cellseq_loopctr.sv
// Module: hardware loop counter for the loop start / loop end pair.
// Assumes load and step are never asserted together.
module cellseq_loopctr #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         again
);
    logic [W-1:0] cnt;

    assign again = (cnt > W'(1));

    // Purpose: hold, load or count down the remaining iterations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step)
            cnt <= again ? cnt - W'(1) : '0;
    end

    AST_LOOP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt > W'(1)) |=> (cnt == $past(cnt) - W'(1))); // R7
    AST_LOOP_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt <= W'(1)) |=> (cnt == '0)); // R7
endmodule

// File: rtl/cellseq_waitctr.sv
// Module: down-counter for control repeats and reset stalls.
// Assumes the sequencer loads it only from the execute state.
module cellseq_waitctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         last
);
    logic [W-1:0] cnt;

    assign busy = (cnt != '0);
    assign last = (cnt == W'(1));

    // Purpose: load the remaining stall cycles and count them away.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (busy)
            cnt <= cnt - W'(1);
    end

    AST_WAIT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (cnt == $past(cnt) - W'(1))); // R4
endmodule

// File: rtl/cellseq_top.sv
// Module: per-cell program sequencer. Fetches from a one-cycle-latency
// program memory, executes one instruction per fetch/execute pair and
// drives datapath strobes. Assumes host_start is a single-cycle pulse.
module cellseq_top
    import cellseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic               pm_rd_en,
    output logic [PC_W-1:0]    pm_addr,
    input  logic [INSTR_W-1:0] pm_rdata,
    input  logic               cond_in,
    input  logic               host_start,
    output logic               status,
    output logic               cfg_valid,
    output logic [CFG_W-1:0]   cfg_data,
    output logic               ctl_valid,
    output logic [CTL_W-1:0]   ctl_data,
    output logic               rst_valid,
    output logic [MASK_W-1:0]  rst_mask,
    output logic               ld_valid,
    output logic [CFG_W-1:0]   ld_data
);
    seq_state_e        state;
    logic [PC_W-1:0]   pc;
    logic [PC_W-1:0]   resume;
    logic [CTL_W-1:0]  held_ctl;
    logic              hold_is_ctl;
    instr_t            dec;
    logic              exec;
    logic              loop_again;
    logic              wc_load, wc_busy, wc_last;
    logic [CNT_W-1:0]  wc_val;
    logic              ctl_long, rst_stall;
    logic [PC_W-1:0]   pc_next;

    cellseq_decode u_dec (
        .word   (pm_rdata),
        .fields (dec)
    );

    cellseq_loopctr #(.W(PC_W)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (exec && dec.op == OP_LOOPS),
        .load_val (dec.loop_n),
        .step     (exec && dec.op == OP_LOOPE),
        .again    (loop_again)
    );

    cellseq_waitctr #(.W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wc_load),
        .load_val (wc_val),
        .busy     (wc_busy),
        .last     (wc_last)
    );

    // Purpose: execute-phase qualifiers and wait counter load value.
    always_comb begin
        exec      = (state == ST_EXEC);
        pc_next   = pc + PC_W'(1);
        ctl_long  = (dec.op == OP_CTL) && (dec.wait_n > CNT_W'(1));
        rst_stall = (dec.op == OP_RST) && (dec.wait_n != '0);
        wc_load   = exec && (ctl_long || rst_stall);
        wc_val    = ctl_long ? dec.wait_n - CNT_W'(1) : dec.wait_n;
    end

    // Purpose: sequencer state, program counter and resume address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_HALT;
            pc          <= '0;
            resume      <= '0;
            held_ctl    <= '0;
            hold_is_ctl <= 1'b0;
        end else begin
            case (state)
                ST_HALT: begin
                    if (host_start) begin
                        pc    <= resume;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_EXEC;
                ST_EXEC: begin
                    state <= ST_FETCH;
                    case (dec.op)
                        OP_JMP:   pc <= dec.target;
                        OP_JZ:    pc <= cond_in ? pc_next : dec.target;
                        OP_LOOPE: pc <= loop_again ? dec.target : pc_next;
                        OP_HALT: begin
                            resume <= dec.target;
                            state  <= ST_HALT;
                        end
                        OP_CTL: begin
                            if (ctl_long) begin
                                held_ctl    <= dec.ctl;
                                hold_is_ctl <= 1'b1;
                                state       <= ST_WAIT;
                            end else begin
                                pc <= pc_next;
                            end
                        end
                        OP_RST: begin
                            if (rst_stall) begin
                                hold_is_ctl <= 1'b0;
                                state       <= ST_WAIT;
                            end else begin
                                pc <= pc_next;
                            end
                        end
                        default:  pc <= pc_next;
                    endcase
                end
                ST_WAIT: begin
                    if (wc_last) begin
                        pc    <= pc_next;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // Purpose: memory port, status and datapath strobes.
    always_comb begin
        pm_rd_en  = (state == ST_FETCH);
        pm_addr   = pc;
        status    = (state == ST_HALT);
        cfg_valid = exec && dec.op == OP_CFG;
        cfg_data  = dec.word16;
        ld_valid  = exec && dec.op == OP_LD;
        ld_data   = dec.word16;
        rst_valid = exec && dec.op == OP_RST;
        rst_mask  = dec.mask;
        ctl_valid = (exec && dec.op == OP_CTL) || (state == ST_WAIT && hold_is_ctl);
        ctl_data  = (state == ST_WAIT) ? held_ctl : dec.ctl;
    end

    AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd_en |=> (!pm_rd_en && $stable(pm_addr))); // R2
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !host_start) |=> (status && $stable(pm_addr))); // R8
    AST_START_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (status && host_start) |=> (!status && pm_rd_en && pm_addr == $past(resume))); // R8
    AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !exec) |=> !status); // R9
    AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dec.op == OP_JZ && !cond_in) |=> (pm_addr == $past(dec.target))); // R6
    AST_WAIT_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> wc_busy); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_valid, ctl_valid, rst_valid, ld_valid})); // R3
endmodule

// File: tb/tb_cellseq_top.sv
module tb_cellseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pm_rd_en;
    logic [6:0]  pm_addr;
    logic [23:0] pm_rdata;
    logic        cond_in = 1'b0;
    logic        host_start = 1'b0;
    logic        status;
    logic        cfg_valid, ctl_valid, rst_valid, ld_valid;
    logic [15:0] cfg_data, ld_data;
    logic [11:0] ctl_data;
    logic [7:0]  rst_mask;

    logic [23:0] mem [128];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];
    logic [6:0]  got_a[$];
    logic [6:0]  exp_a[$];
    logic [6:0]  exp_resume = '0;
    int          lc_m = 0;
    int          exp_cyc;
    bit          done = 0;

    always #10 clk = ~clk;

    cellseq_top dut (
        .clk(clk), .rst_n(rst_n), .pm_rd_en(pm_rd_en), .pm_addr(pm_addr),
        .pm_rdata(pm_rdata), .cond_in(cond_in), .host_start(host_start),
        .status(status), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
        .ctl_valid(ctl_valid), .ctl_data(ctl_data), .rst_valid(rst_valid),
        .rst_mask(rst_mask), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    always_ff @(posedge clk) pm_rdata <= mem[pm_addr];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (cfg_valid) got_q.push_back({4'd1, 12'd0, cfg_data});
            if (ctl_valid) got_q.push_back({4'd2, 16'd0, ctl_data});
            if (rst_valid) got_q.push_back({4'd3, 20'd0, rst_mask});
            if (ld_valid)  got_q.push_back({4'd4, 12'd0, ld_data});
            if (pm_rd_en)  got_a.push_back(pm_addr);
        end
        if (cyc > 190000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0d exp<190000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] f_cfg(input logic [15:0] d);   return {4'd1, 4'd0, d}; endfunction
    function automatic logic [23:0] f_ctl(input logic [11:0] c, input logic [7:0] w); return {4'd2, c, w}; endfunction
    function automatic logic [23:0] f_jmp(input logic [6:0] t);    return {4'd3, 13'd0, t}; endfunction
    function automatic logic [23:0] f_jz(input logic [6:0] t);     return {4'd4, 13'd0, t}; endfunction
    function automatic logic [23:0] f_lps(input logic [6:0] n);    return {4'd5, 13'd0, n}; endfunction
    function automatic logic [23:0] f_lpe(input logic [6:0] t);    return {4'd6, 13'd0, t}; endfunction
    function automatic logic [23:0] f_halt(input logic [6:0] t);   return {4'd7, 13'd0, t}; endfunction
    function automatic logic [23:0] f_rst(input logic [7:0] m, input logic [7:0] w); return {4'd8, 4'd0, m, w}; endfunction
    function automatic logic [23:0] f_ld(input logic [15:0] d);    return {4'd9, 4'd0, d}; endfunction

    // Instruction-level model from the requirements: fills exp_q, exp_a, exp_cyc.
    task automatic model_run();
        logic [6:0] pc = exp_resume;
        exp_q.delete(); exp_a.delete(); exp_cyc = 0;
        for (int step = 0; step < 4000; step++) begin
            logic [23:0] w = mem[pc];
            int n = int'(w[7:0]);
            exp_a.push_back(pc);
            exp_cyc += 2;
            case (w[23:20])
                4'd1: begin exp_q.push_back({4'd1, 12'd0, w[15:0]}); pc = pc + 7'd1; end
                4'd2: begin
                    int reps = (n < 2) ? 1 : n;
                    for (int r = 0; r < reps; r++) exp_q.push_back({4'd2, 16'd0, w[19:8]});
                    exp_cyc += reps - 1; pc = pc + 7'd1;
                end
                4'd3: pc = w[6:0];
                4'd4: pc = cond_in ? pc + 7'd1 : w[6:0];
                4'd5: begin lc_m = int'(w[6:0]); pc = pc + 7'd1; end
                4'd6: begin
                    if (lc_m > 1) begin lc_m--; pc = w[6:0]; end
                    else begin lc_m = 0; pc = pc + 7'd1; end
                end
                4'd7: begin exp_resume = w[6:0]; return; end
                4'd8: begin exp_q.push_back({4'd3, 20'd0, w[15:8]}); exp_cyc += n; pc = pc + 7'd1; end
                4'd9: begin exp_q.push_back({4'd4, 12'd0, w[15:0]}); pc = pc + 7'd1; end
                default: pc = pc + 7'd1;
            endcase
        end
    endtask

    // Starts the cell, optionally pulses a stray start at run cycle spur, compares.
    task automatic run_prog(input string tag, input int spur);
        int cnt = 0;
        model_run();
        got_q.delete(); got_a.delete();
        @(negedge clk); host_start = 1'b1;
        @(negedge clk);
        while (1) begin
            host_start = 1'b0;
            if (status || cnt > 5000) break;
            cnt++;
            if (cnt == spur) host_start = 1'b1;
            @(negedge clk);
        end
        host_start = 1'b0;
        chk({tag, " R2 R4 R10 run length"}, cnt, exp_cyc);
        chk({tag, " R3 R4 R10 R11 strobe count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
            case (exp_q[i][31:28])
                4'd2:    chk({tag, " R4 control strobe"}, got_q[i], exp_q[i]);
                4'd3:    chk({tag, " R10 reset strobe"}, got_q[i], exp_q[i]);
                default: chk({tag, " R3 config/load strobe"}, got_q[i], exp_q[i]);
            endcase
        end
        chk({tag, " R2 R5 R6 R7 fetch count"}, got_a.size(), exp_a.size());
        for (int i = 0; i < got_a.size() && i < exp_a.size(); i++)
            chk({tag, " R2 R5 R6 R7 fetch address"}, {25'd0, got_a[i]}, {25'd0, exp_a[i]});
        chk({tag, " R8 halted after run"}, {31'd0, status}, 32'd1);
        if (spur > 0) chk({tag, " R9 stray start ignored"}, cnt, exp_cyc);
    endtask

    initial begin
        int seed = $urandom(32'd1357);
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", {31'd0, status}, 32'd1);
        chk("R1 strobes in reset", {28'd0, cfg_valid, ctl_valid, rst_valid, ld_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {30'd0, status, pm_rd_en}, 32'd2);

        // Directed: strobes, counts, undefined opcode, halt target 40.
        mem[0] = f_cfg(16'h1234);  mem[1] = f_ld(16'h5678);
        mem[2] = 24'hB0_0000;      mem[3] = f_ctl(12'hABC, 8'd0);
        mem[4] = f_ctl(12'h111, 8'd1); mem[5] = f_ctl(12'h222, 8'd5);
        mem[6] = f_rst(8'h5A, 8'd3);   mem[7] = f_rst(8'h33, 8'd0);
        mem[8] = 24'hF0_0000;      mem[9] = f_halt(7'd40);
        mem[40] = f_cfg(16'hBEEF); mem[41] = f_halt(7'd0);
        run_prog("R1 first start", 0);
        run_prog("R8 resume at target", 0);

        // Directed: loop counts 0, 1, 3 with jump and both conditions.
        for (int k = 0; k < 3; k++) begin
            mem[0] = f_lps(k == 0 ? 7'd0 : (k == 1 ? 7'd1 : 7'd3));
            mem[1] = f_ctl(12'h0F0, 8'd2); mem[2] = f_lpe(7'd1);
            mem[3] = f_jz(7'd5); mem[4] = f_cfg(16'h0044);
            mem[5] = f_jmp(7'd7); mem[6] = f_cfg(16'hDEAD); mem[7] = f_halt(7'd0);
            cond_in = k[0];
            run_prog("R7 R6 R5 directed loop", 0);
        end

        // Random programs with a loop, JZ, JMP and stray starts.
        for (int p = 0; p < 40; p++) begin
            int k = 1 + int'($urandom % 4);
            int a;
            for (int i = 0; i < 16; i++) mem[i] = '0;
            mem[0] = f_lps(7'($urandom % 7));
            for (int i = 1; i <= k; i++) begin
                case ($urandom % 5)
                    0: mem[i] = f_cfg(16'($urandom));
                    1: mem[i] = f_ctl(12'($urandom), 8'($urandom % 5));
                    2: mem[i] = f_rst(8'($urandom), 8'($urandom % 4));
                    3: mem[i] = f_ld(16'($urandom));
                    default: mem[i] = {4'hC, 20'($urandom)};
                endcase
            end
            a = k + 2;
            mem[k+1] = f_lpe(7'd1);
            mem[a]   = f_jz(7'(a + 2));
            mem[a+1] = f_cfg(16'($urandom));
            mem[a+2] = f_jmp(7'(a + 4));
            mem[a+3] = f_cfg(16'hDEAD);
            mem[a+4] = f_halt(7'd0);
            cond_in = 1'($urandom);
            run_prog("random", (p % 2 == 1) ? 1 + int'($urandom % 6) : 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule